// File: doc/BRIEF.md
# Converter Result Byte Bridge

This block lets a processor or DMA engine with an 8-bit data bus read the 12-bit result of a successive-approximation converter. It watches the converter's busy flag. When that flag drops, the result on the converter's data lines is valid, and the block stores it. A bus write pulses a start strobe toward the converter and clears the block's data-ready flag. The flag comes back when the next result has been stored.

Bus reads use a level read strobe and a single byte-select bit. Byte select 0 always returns the byte that carries the most-significant bits of the result. Byte select 1 returns the other byte. Static configuration inputs control three things:
- the packing, left-justified or right-justified;
- whether the live busy status is placed in a spare bit of the nibble byte, so that one access both polls the converter and reads the partial byte;
- whether the MSB is inverted, which turns complementary offset-binary data into complementary two's-complement data.

In left-justified packing, byte 0 alone is a coarse 8-bit reading, so a reader that only needs that much can skip the second byte. If a result arrives while a read strobe is active, the stored result stays unchanged until the strobe ends. This keeps a two-byte read coherent.

Top module: `adcByteBridge`

## Requirements
- R1: When the busy input is 1 in one clock and 0 in the next clock, the 12-bit data input in that second clock is stored as the result, provided the read strobe is low. In the same edge dataReady goes to 1, and the new result is readable in the following cycle.
- R2: With cfgLeftJust=1, byte select 0 reads result bits 11..4 as bits 7..0. Byte select 1 reads result bits 3..0 in bits 7..4, with bits 3..1 reading 0.
- R3: With cfgLeftJust=0, byte select 1 reads result bits 7..0. Byte select 0 reads result bits 11..8 in bits 3..0, with bits 6..4 reading 0.
- R4: The status position of the nibble byte reads the busy input as sampled at the last clock edge when cfgStatusEn=1, and reads 0 when cfgStatusEn=0. That position is bit 0 of byte select 1 with left packing, and bit 7 of byte select 0 with right packing.
- R5: If the busy input falls while busRd=1, the result is not changed while busRd stays 1. The new word is stored, and dataReady set, at the first clock edge at which busRd=0.
- R6: A rising edge of busWr makes convStart 1 for exactly one clock, starting the cycle after the edge. In that same edge dataReady is cleared and any held-off result is discarded.
- R7: With cfgTwosComp=1, result bit 11 is read inverted wherever it appears. All other bits are unaffected.
- R8: busRdData reads 0 whenever busRd=0.
- R9: After reset, dataReady=0, convStart=0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convData | input | 12 | Converter parallel result |
| convBusy | input | 1 | Converter busy flag, 1 while converting |
| convStart | output | 1 | One-clock start strobe to the converter |
| cfgLeftJust | input | 1 | 1 selects left-justified packing, 0 selects right-justified |
| cfgStatusEn | input | 1 | 1 places the busy status in the nibble byte |
| cfgTwosComp | input | 1 | 1 inverts the result MSB on reads |
| busRd | input | 1 | Read strobe (level) |
| busWr | input | 1 | Write strobe; its rising edge starts a conversion |
| busAddr | input | 1 | Byte select |
| busRdData | output | 8 | Read data |
| dataReady | output | 1 | A result has been stored since the last start |

## Verification
Random 12-bit results are read back under every mix of packing, status placement and MSB inversion. Comparing both bytes against a bench model separates a swapped byte, a misplaced nibble and a wrong status position. Status reads are taken both while the busy flag is high and after it has dropped, so a constant or stale status bit shows up. Directed cases cover a result arriving during a read, a start write issued while a result is held off, and all-zero and all-one words that expose stuck bits in the MSB inversion.

// File: rtl/adcBridgePkg.sv
package adcBridgePkg;

  // Strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic loadDirect; // store converter word into result now
    logic loadStage;  // park converter word, a read is active
    logic commit;     // move parked word into result
  } bridgeStrobes_t;

endpackage

// File: rtl/adcBridgeCtrl.sv
module adcBridgeCtrl
  import adcBridgePkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           convBusy,
  input  logic           busRd,
  input  logic           busWr,
  output bridgeStrobes_t strobes,
  output logic           busyStatus,
  output logic           convStart,
  output logic           dataReady
);

  logic busyQ;
  logic wrQ;
  logic pendQ;
  logic readyQ;
  logic startQ;
  logic busyFall;
  logic wrEdge;

  assign busyFall = busyQ & ~convBusy;
  assign wrEdge   = busWr & ~wrQ;

  always_comb begin
    strobes.loadDirect = busyFall & ~busRd;
    strobes.loadStage  = busyFall & busRd;
    strobes.commit     = pendQ & ~busRd & ~busyFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      wrQ    <= 1'b0;
      pendQ  <= 1'b0;
      readyQ <= 1'b0;
      startQ <= 1'b0;
    end else begin
      busyQ  <= convBusy;
      wrQ    <= busWr;
      startQ <= wrEdge;
      if (wrEdge) begin
        pendQ  <= 1'b0;
        readyQ <= 1'b0;
      end else begin
        if (strobes.loadStage)
          pendQ <= 1'b1;
        else if (strobes.commit || strobes.loadDirect)
          pendQ <= 1'b0;
        if (strobes.loadDirect || strobes.commit)
          readyQ <= 1'b1;
      end
    end
  end

  assign busyStatus = busyQ;
  assign convStart  = startQ;
  assign dataReady  = readyQ;

  // R6: start strobe never lasts two cycles
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R5: ready only rises from an edge where no read was active
  assert_ready_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> !$past(busRd));

endmodule

// File: rtl/adcByteFormatter.sv
module adcByteFormatter #(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic              cfgLeftJust,
  input  logic              cfgStatusEn,
  input  logic              cfgTwosComp,
  input  logic              busyStatus,
  input  logic              busRd,
  input  logic              busAddr,
  output logic [BUS_W-1:0]  busRdData
);

  localparam int NIB_W = DATA_W - BUS_W;

  logic [DATA_W-1:0] fixWord;
  logic [BUS_W-1:0]  hiByte;
  logic [BUS_W-1:0]  loByte;
  logic              statBit;

  always_comb begin
    fixWord = word;
    fixWord[DATA_W-1] = word[DATA_W-1] ^ cfgTwosComp;
    statBit = cfgStatusEn & busyStatus;
    hiByte = '0;
    loByte = '0;
    if (cfgLeftJust) begin
      hiByte = fixWord[DATA_W-1 -: BUS_W];
      loByte[BUS_W-1 -: NIB_W] = fixWord[NIB_W-1:0];
      loByte[0] = statBit;
    end else begin
      hiByte[NIB_W-1:0] = fixWord[DATA_W-1:BUS_W];
      hiByte[BUS_W-1] = statBit;
      loByte = fixWord[BUS_W-1:0];
    end
    if (!busRd)
      busRdData = '0;
    else if (busAddr)
      busRdData = loByte;
    else
      busRdData = hiByte;
  end

endmodule

// File: rtl/adcBridgeDatapath.sv
module adcBridgeDatapath
  import adcBridgePkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrobes_t    strobes,
  input  logic [DATA_W-1:0] convData,
  input  logic              busyStatus,
  input  logic              cfgLeftJust,
  input  logic              cfgStatusEn,
  input  logic              cfgTwosComp,
  input  logic              busRd,
  input  logic              busAddr,
  output logic [BUS_W-1:0]  busRdData
);

  logic [DATA_W-1:0] stageWord;
  logic [DATA_W-1:0] resultWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageWord  <= '0;
      resultWord <= '0;
    end else begin
      if (strobes.loadStage)
        stageWord <= convData;
      if (strobes.loadDirect)
        resultWord <= convData;
      else if (strobes.commit)
        resultWord <= stageWord;
    end
  end

  adcByteFormatter #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_fmt (
    .word       (resultWord),
    .cfgLeftJust(cfgLeftJust),
    .cfgStatusEn(cfgStatusEn),
    .cfgTwosComp(cfgTwosComp),
    .busyStatus (busyStatus),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .busRdData  (busRdData)
  );

  // R5: result frozen across a continuing read
  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && $past(busRd)) |-> $stable(resultWord));

  // R1: control never issues two load actions at once
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadDirect, strobes.loadStage, strobes.commit}));

endmodule

// File: rtl/adcByteBridge.sv
module adcByteBridge
  import adcBridgePkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] convData,
  input  logic              convBusy,
  output logic              convStart,
  input  logic              cfgLeftJust,
  input  logic              cfgStatusEn,
  input  logic              cfgTwosComp,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busAddr,
  output logic [BUS_W-1:0]  busRdData,
  output logic              dataReady
);

  bridgeStrobes_t strobes;
  logic           busyStatus;

  adcBridgeCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convBusy  (convBusy),
    .busRd     (busRd),
    .busWr     (busWr),
    .strobes   (strobes),
    .busyStatus(busyStatus),
    .convStart (convStart),
    .dataReady (dataReady)
  );

  adcBridgeDatapath #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .convData   (convData),
    .busyStatus (busyStatus),
    .cfgLeftJust(cfgLeftJust),
    .cfgStatusEn(cfgStatusEn),
    .cfgTwosComp(cfgTwosComp),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .busRdData  (busRdData)
  );

  // R6: dataReady is low while the start strobe is out
  assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !dataReady);

endmodule

// File: tb/test_adcByteBridge.sv
`timescale 1ns/1ps
module test_adcByteBridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] convData = '0;
  logic        convBusy = 1'b0;
  logic        convStart;
  logic        cfgLeftJust = 1'b1;
  logic        cfgStatusEn = 1'b0;
  logic        cfgTwosComp = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic        busAddr = 1'b0;
  logic [7:0]  busRdData;
  logic        dataReady;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [11:0] model = '0;
  logic        busyModel = 1'b0;

  always #2 clk = ~clk;

  adcByteBridge i_adcByteBridge (
    .clk(clk), .rstN(rstN), .convData(convData), .convBusy(convBusy),
    .convStart(convStart), .cfgLeftJust(cfgLeftJust), .cfgStatusEn(cfgStatusEn),
    .cfgTwosComp(cfgTwosComp), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busRdData(busRdData), .dataReady(dataReady)
  );

  function automatic logic [7:0] expByte(logic [11:0] w, logic lj, logic se,
                                         logic tc, logic bz, logic ad);
    logic [11:0] f;
    logic s;
    f = w ^ {tc, 11'b0};
    s = se & bz;
    if (lj) return ad ? {f[3:0], 3'b000, s} : f[11:4];
    else    return ad ? f[7:0] : {s, 3'b000, f[11:8]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // read a byte without crossing a clock edge
  task automatic readChk(input string req, input logic ad);
    busAddr = ad;
    busRd = 1'b1;
    #0.5;
    check(req, busRdData,
          expByte(model, cfgLeftJust, cfgStatusEn, cfgTwosComp, busyModel, ad));
    busRd = 1'b0;
    #0.5;
  endtask

  // one conversion ending with a falling busy flag, read strobe low
  task automatic convert(input logic [11:0] val, input string req);
    convBusy = 1'b1;
    convData = 12'($urandom);
    step();
    busyModel = 1'b1;
    if (cfgStatusEn) readChk("R4 status busy", cfgLeftJust ? 1'b1 : 1'b0);
    convBusy = 1'b0;
    convData = val;
    step();
    busyModel = 1'b0;
    model = val;
    check({req, " ready"}, {7'b0, dataReady}, 8'h01);
  endtask

  task automatic startWrite();
    busWr = 1'b1;
    step();
    check("R6 start high", {7'b0, convStart}, 8'h01);
    check("R6 ready cleared", {7'b0, dataReady}, 8'h00);
    step();
    check("R6 start one cycle", {7'b0, convStart}, 8'h00);
    busWr = 1'b0;
    step();
    check("R6 no second start", {7'b0, convStart}, 8'h00);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) step();
    check("R9 ready reset", {7'b0, dataReady}, 8'h00);
    check("R9 start reset", {7'b0, convStart}, 8'h00);
    readChk("R9 result zero", 1'b0);
    readChk("R9 result zero", 1'b1);
    rstN = 1'b1;
    step();
    check("R8 idle bus zero", busRdData, 8'h00);

    startWrite();
    convert(12'h9A5, "R1");
    readChk("R2 left msb byte", 1'b0);
    readChk("R2 left nibble byte", 1'b1);
    cfgLeftJust = 1'b0;
    readChk("R3 right msb nibble", 1'b0);
    readChk("R3 right low byte", 1'b1);
    cfgTwosComp = 1'b1;
    readChk("R7 inverted msb right", 1'b0);
    cfgLeftJust = 1'b1;
    readChk("R7 inverted msb left", 1'b0);
    cfgTwosComp = 1'b0;

    // corner words
    cfgStatusEn = 1'b1;
    convert(12'hFFF, "R1");
    readChk("R4 status idle left", 1'b1);
    readChk("R2 all ones", 1'b0);
    cfgTwosComp = 1'b1;
    convert(12'h000, "R1");
    readChk("R7 zero word msb", 1'b0);
    cfgLeftJust = 1'b0;
    readChk("R4 status idle right", 1'b0);
    cfgTwosComp = 1'b0;

    // capture during an active read
    cfgLeftJust = 1'b1;
    cfgStatusEn = 1'b0;
    busAddr = 1'b0;
    busRd = 1'b1;
    convBusy = 1'b1;
    step();
    convBusy = 1'b0;
    convData = 12'h5C3;
    step();
    step();
    check("R5 old value during read", busRdData, expByte(model, 1, 0, 0, 0, 0));
    busRd = 1'b0;
    step();
    model = 12'h5C3;
    check("R5 ready after read", {7'b0, dataReady}, 8'h01);
    readChk("R5 committed msb", 1'b0);
    readChk("R5 committed nibble", 1'b1);

    // start write discards a held-off word
    busRd = 1'b1;
    convBusy = 1'b1;
    step();
    convBusy = 1'b0;
    convData = 12'h0F0;
    step();
    busWr = 1'b1;
    step();
    busWr = 1'b0;
    busRd = 1'b0;
    step();
    step();
    check("R6 held word discarded ready", {7'b0, dataReady}, 8'h00);
    readChk("R6 held word discarded data", 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      cfgLeftJust = 1'($urandom);
      cfgStatusEn = 1'($urandom);
      cfgTwosComp = 1'($urandom);
      if (i % 7 == 0) startWrite();
      convert(12'($urandom), "R1");
      readChk("R2 R3 random msb side", 1'b0);
      readChk("R2 R3 random nibble side", 1'b1);
      check("R8 idle bus zero", busRdData, 8'h00);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule